// File: doc/BRIEF.md
# Erase and Multi-Trace Cycle Timer

This block produces the cycle pulse that paces the erase and multi-trace sequences of a storage display. Three separate events can start a pulse. An erase command starts one. A single-sweep reset request can start an externally initiated multi-trace cycle. The end of a transfer pulse can start an automatically recurring multi-trace cycle. The active-high pulse `x_o` and its complement `x_n_o` drive the downstream sequencing logic.

The pulse length depends on the event that started it and on the multi flag. There are three lengths: a long erase length, a short fixed length, and a variable length taken from a delay setting. All lengths are counted in scaled ticks. Each tick is `TICK_DIV` clock cycles long, so with the default parameters one tick is one millisecond at 100 MHz. The pulse cannot be retriggered. A set of inhibit inputs blocks every start event.

Top module: `cycle_timer`

## Requirements
- R1: A rising edge on `erase_i` starts a pulse. `x_o` rises on the clock edge that samples the edge. It stays high for exactly `ERASE_TICKS*TICK_DIV` cycles.
- R2: A rising edge on `sweep_rst_i` starts a pulse only when `detent_i` is 1 or `rep_sweep_i` is 0, and only while `w_busy_i` is 0. With `multi_i` = 1 the pulse lasts `FIXED_TICKS*TICK_DIV` cycles.
- R3: A falling edge on `xfer_i` (1 to 0) starts a pulse only when `rep_sweep_i` is 1 and `detent_i` is 0. A rising edge on `xfer_i` starts nothing.
- R4: With `multi_i` = 1, a pulse started by R3 lasts `(VAR_MIN + floor((VAR_MAX-VAR_MIN)*d/(2^DLY_W-1)))*TICK_DIV` cycles, where d is the unsigned value of `dly_i` in the start cycle.
- R5: With `multi_i` = 0, pulses started through R2 or R3 use the erase length `ERASE_TICKS`.
- R6: No start event has any effect while `stor_sel_i` is 0, `save_i` is 1 or `fast_i` is 1.
- R7: Any start event that arrives while `x_o` is high is dropped. The running pulse keeps its length, and no second pulse follows it.
- R8: When several start events occur in the same cycle, the erase event wins and sets the length.
- R9: `x_n_o` is always the inverse of `x_o`. During reset and after reset, `x_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| erase_i | input | 1 | Erase command (rising edge starts) |
| sweep_rst_i | input | 1 | Single-sweep reset request (rising edge starts) |
| xfer_i | input | 1 | Transfer pulse (falling edge starts) |
| rep_sweep_i | input | 1 | 1 = repetitive sweep, 0 = single sweep |
| detent_i | input | 1 | 1 = delay control in detent |
| dly_i | input | DLY_W | Delay setting for the variable length |
| multi_i | input | 1 | Multi flag |
| w_busy_i | input | 1 | 1 = a previous sequence is still running |
| save_i | input | 1 | Inhibit: save active |
| fast_i | input | 1 | Inhibit: fast active |
| stor_sel_i | input | 1 | 0 inhibits all starts (no storage mode selected) |
| x_o | output | 1 | Cycle pulse |
| x_n_o | output | 1 | Complement of the cycle pulse |

## Verification
A wrong internal state shows up at `x_o` by the end of the pulse it affects. A length loaded wrongly or a bad prescaler shows as a high time that is off by whole ticks. A lost edge register shows as a missing pulse, or as a pulse on the wrong edge of `xfer_i`, in the cycle after the stimulus. A broken idle gate shows as a second pulse or a longer pulse within one pulse length. The bench measures each high time cycle by cycle on a small configuration and sweeps every delay code, so an error of a single cycle is reported.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ERASE = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_AUTO  = 2'd3
  } trig_src_e;
endpackage

// File: rtl/ct_rst_sync.sv
module ct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ct_trig_qual.sv
module ct_trig_qual
  import cycle_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      erase_i,
  input  logic      sweep_rst_i,
  input  logic      xfer_i,
  input  logic      rep_sweep_i,
  input  logic      detent_i,
  input  logic      w_busy_i,
  input  logic      save_i,
  input  logic      fast_i,
  input  logic      stor_sel_i,
  input  logic      busy_i,
  output logic      start_o,
  output trig_src_e src_o
);
  logic erase_q, swr_q, xfer_q;
  logic erase_d, swr_d, xfer_d;
  logic inhibit, c_erase, c_ext, c_auto;

  // previous-value registers for edge detection (always enabled)
  always_comb begin
    erase_d = erase_i;
    swr_d   = sweep_rst_i;
    xfer_d  = xfer_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      swr_q   <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      erase_q <= erase_d;
      swr_q   <= swr_d;
      xfer_q  <= xfer_d;
    end
  end

  always_comb begin
    inhibit = !stor_sel_i || save_i || fast_i || busy_i;
    c_erase = erase_i && !erase_q;
    c_ext   = sweep_rst_i && !swr_q && (detent_i || !rep_sweep_i) && !w_busy_i;
    c_auto  = !xfer_i && xfer_q && rep_sweep_i && !detent_i;
    src_o   = SRC_NONE;
    if (!inhibit) begin
      if (c_erase)     src_o = SRC_ERASE;
      else if (c_ext)  src_o = SRC_EXT;
      else if (c_auto) src_o = SRC_AUTO;
    end
    start_o = (src_o != SRC_NONE);
  end
endmodule

// File: rtl/ct_dur_sel.sv
module ct_dur_sel
  import cycle_timer_pkg::*;
#(
  parameter int ERASE_TICKS = 900,
  parameter int FIXED_TICKS = 150,
  parameter int VAR_MIN     = 150,
  parameter int VAR_MAX     = 4000,
  parameter int DLY_W       = 8,
  parameter int CW          = 12
) (
  input  trig_src_e        src_i,
  input  logic             multi_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [CW-1:0]    dur_o
);
  localparam int SPAN = VAR_MAX - VAR_MIN;
  localparam int DMAX = (1 << DLY_W) - 1;

  int unsigned var_ticks;

  always_comb begin
    var_ticks = VAR_MIN + (SPAN * int'(dly_i)) / DMAX;
    unique case (src_i)
      SRC_EXT:  dur_o = multi_i ? CW'(FIXED_TICKS) : CW'(ERASE_TICKS);
      SRC_AUTO: dur_o = multi_i ? CW'(var_ticks)   : CW'(ERASE_TICKS);
      default:  dur_o = CW'(ERASE_TICKS);
    endcase
    if (src_i == SRC_AUTO && multi_i) begin
      AST_VAR_RANGE: assert (int'(dur_o) >= VAR_MIN && int'(dur_o) <= VAR_MAX); // R4
    end
  end
endmodule

// File: rtl/ct_pulse_cnt.sv
module ct_pulse_cnt #(
  parameter int TICK_DIV = 100000,
  parameter int CW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] dur_i,
  output logic          x_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic          x_q, x_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          tick;

  always_comb begin
    tick  = x_q && (pre_q == PW'(TICK_DIV - 1));
    x_d   = x_q;
    cnt_d = cnt_q;
    pre_d = pre_q;
    if (!x_q && start_i) begin
      x_d   = 1'b1;
      cnt_d = dur_i;
      pre_d = '0;
    end else if (x_q) begin
      if (tick) begin
        pre_d = '0;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) x_d = 1'b0;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      x_q   <= x_d;
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  assign x_o = x_q;

  AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (x_q && cnt_q == $past(dur_i))); // R1
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !x_q); // R7
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q && !(tick && cnt_q == CW'(1))) |=> x_q); // R7
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(x_q) |-> ($past(tick) && $past(cnt_q) == CW'(1))); // R1
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
#(
  parameter int TICK_DIV    = 100000,
  parameter int ERASE_TICKS = 900,
  parameter int FIXED_TICKS = 150,
  parameter int VAR_MIN     = 150,
  parameter int VAR_MAX     = 4000,
  parameter int DLY_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_i,
  input  logic             sweep_rst_i,
  input  logic             xfer_i,
  input  logic             rep_sweep_i,
  input  logic             detent_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             multi_i,
  input  logic             w_busy_i,
  input  logic             save_i,
  input  logic             fast_i,
  input  logic             stor_sel_i,
  output logic             x_o,
  output logic             x_n_o
);
  localparam int MAX_A = (ERASE_TICKS > VAR_MAX) ? ERASE_TICKS : VAR_MAX;
  localparam int MAXT  = (MAX_A > FIXED_TICKS) ? MAX_A : FIXED_TICKS;
  localparam int CW    = $clog2(MAXT + 1);

  logic          rst_n_s;
  logic          start;
  trig_src_e     src;
  logic [CW-1:0] dur;
  logic          x_int;

  ct_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ct_trig_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .erase_i     (erase_i),
    .sweep_rst_i (sweep_rst_i),
    .xfer_i      (xfer_i),
    .rep_sweep_i (rep_sweep_i),
    .detent_i    (detent_i),
    .w_busy_i    (w_busy_i),
    .save_i      (save_i),
    .fast_i      (fast_i),
    .stor_sel_i  (stor_sel_i),
    .busy_i      (x_int),
    .start_o     (start),
    .src_o       (src)
  );

  ct_dur_sel #(
    .ERASE_TICKS (ERASE_TICKS),
    .FIXED_TICKS (FIXED_TICKS),
    .VAR_MIN     (VAR_MIN),
    .VAR_MAX     (VAR_MAX),
    .DLY_W       (DLY_W),
    .CW          (CW)
  ) u_dur (
    .src_i   (src),
    .multi_i (multi_i),
    .dly_i   (dly_i),
    .dur_o   (dur)
  );

  ct_pulse_cnt #(
    .TICK_DIV (TICK_DIV),
    .CW       (CW)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start),
    .dur_i   (dur),
    .x_o     (x_int)
  );

  assign x_o   = x_int;
  assign x_n_o = ~x_int;

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((!stor_sel_i || save_i || fast_i) && !x_int) |=> !x_int); // R6
endmodule

// File: tb/test_cycle_timer.sv
module test_cycle_timer;
  localparam int TD = 2, ER = 9, FX = 3, VMIN = 3, VMAX = 18, DW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic erase, swr, xfer, rep, detent, multi, wbusy, save, fast, ssel;
  logic [DW-1:0] dly;
  logic x, xn;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cycle_timer #(
    .TICK_DIV (TD), .ERASE_TICKS (ER), .FIXED_TICKS (FX),
    .VAR_MIN (VMIN), .VAR_MAX (VMAX), .DLY_W (DW)
  ) i_cycle_timer (
    .clk (clk), .rst_n (rst_n), .erase_i (erase), .sweep_rst_i (swr),
    .xfer_i (xfer), .rep_sweep_i (rep), .detent_i (detent), .dly_i (dly),
    .multi_i (multi), .w_busy_i (wbusy), .save_i (save), .fast_i (fast),
    .stor_sel_i (ssel), .x_o (x), .x_n_o (xn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // count the high cycles of x from the next negedge; also checks x_n (R9)
  task automatic measure(input int exp_cycles, input string tag);
    int n = 0;
    bit compl_ok = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (xn !== ~x) compl_ok = 1'b0;
      if (x === 1'b1) n++;
      if (n > 0 && x === 1'b0) break;
    end
    check(n == exp_cycles, tag, n, exp_cycles);
    check(compl_ok, "R9 complement", int'(compl_ok), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic defaults;
    erase = 0; swr = 0; xfer = 0; rep = 1; detent = 0; multi = 1;
    wbusy = 0; save = 0; fast = 0; ssel = 1; dly = '0;
  endtask

  task automatic pulse_erase(input int exp, input string tag);
    erase = 1; measure(exp, tag); erase = 0; idle(2);
  endtask

  task automatic pulse_swr(input int exp, input string tag);
    swr = 1; measure(exp, tag); swr = 0; idle(2);
  endtask

  task automatic pulse_xfer(input int exp, input string tag);
    xfer = 1; measure(0, "R3 rising edge of transfer ignored");
    xfer = 0; measure(exp, tag); idle(2);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 0;
    idle(3);
    check(x === 1'b0 && xn === 1'b1, "R9 reset state", int'(x), 0);
    @(negedge clk); rst_n = 1;
    idle(4);
    check(x === 1'b0 && xn === 1'b1, "R9 after reset", int'(x), 0);

    // R1 erase
    pulse_erase(ER * TD, "R1 erase length");
    multi = 0; pulse_erase(ER * TD, "R1 erase length multi=0");
    multi = 1;

    // R2 external start
    rep = 1; detent = 1; pulse_swr(FX * TD, "R2 detent start");
    rep = 0; detent = 0; pulse_swr(FX * TD, "R2 single-sweep start");
    rep = 1; detent = 0; pulse_swr(0, "R2 blocked repetitive out of detent");
    rep = 0; wbusy = 1;  pulse_swr(0, "R2 blocked by w busy");
    wbusy = 0;

    // R3 / R4 auto recurrence, every delay code
    rep = 1; detent = 0; multi = 1;
    for (int d = 0; d < (1 << DW); d++) begin
      dly = DW'(d);
      pulse_xfer((VMIN + ((VMAX - VMIN) * d) / ((1 << DW) - 1)) * TD, "R4 variable length");
    end
    dly = '0;
    rep = 0; pulse_xfer(0, "R3 blocked single sweep");
    rep = 1; detent = 1; pulse_xfer(0, "R3 blocked in detent");
    detent = 0;

    // R5 multi low
    multi = 0;
    pulse_xfer(ER * TD, "R5 auto uses erase length");
    detent = 1; pulse_swr(ER * TD, "R5 external uses erase length");
    detent = 0; multi = 1;

    // R6 inhibits
    save = 1; pulse_erase(0, "R6 save blocks"); save = 0;
    fast = 1; pulse_erase(0, "R6 fast blocks"); fast = 0;
    ssel = 0; detent = 1; pulse_swr(0, "R6 no storage mode blocks");
    ssel = 1; detent = 0;
    pulse_erase(ER * TD, "R6 erase after inhibits released");

    // R7 non-retriggerable
    erase = 1; idle(3); erase = 0; idle(2); erase = 1;
    measure(ER * TD - 5, "R7 retrigger ignored, remaining length");
    erase = 0;
    measure(0, "R7 no second pulse");

    // R8 priority: erase with external start in same cycle
    detent = 1; multi = 1;
    erase = 1; swr = 1;
    measure(ER * TD, "R8 erase wins");
    erase = 0; swr = 0; detent = 0;
    idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule